// File: doc/BRIEF.md
# Vectored Nesting Priority Interrupt Unit

This unit maps up to sixteen programmable vector slots onto thirty-two interrupt sources. Each slot carries a service address and a control byte that binds it to one source. A slot's position sets its priority, so slot 0 outranks slot 15. A default vector at level 16 catches every pending source that no enabled slot claims. The unit tracks the level now in service, so interrupt service routines can nest.

Software acknowledges an interrupt by reading the vector register. The read raises the service level to the best pending slot, records the level it left, and returns that slot's address. A write of any value to the same register ends the routine and drops back to the recorded level. The IRQ output is masked so that only sources strictly above the level in service can raise it. Raw pending bits (hardware or software) and an IRQ-eligible mask arrive from a companion register block.

Top module: `vnp_irq_nest`

## Requirements
- R1: After reset every slot address, slot control and the default vector read zero, `irq_out` is low, and the service level is idle (17), so any eligible pending source raises `irq_out`.
- R2: Register words, by word address: 12 is the vector register, 13 is the default vector, 64+k is the address of slot k, and 128+k is the control of slot k (k = 0..15). Slot and default words read back what was written, with slot controls keeping the low 8 bits. Any other word reads zero and ignores writes.
- R3: In a slot control byte, bit 5 enables the slot and bits 4:0 name its source. A source with no enabled slot is unvectored. A change to a control takes effect on the next acknowledge.
- R4: One clock after any state change, `irq_out` equals the OR of `src_pend & src_elig & M`. M is the mask of the current level: the sources of enabled slots with a lower index than the level; all claimed sources at level 16; all ones at idle.
- R5: A read of word 12 returns the address of the highest-priority level whose mask, taken one level deeper, meets the raw pending bits. The level is searched only above the current one, and the read makes that level current. An unvectored source reaches level 16 and returns the default vector.
- R6: A read of word 12 with no pending source above the current level returns the current level's address and leaves the level unchanged.
- R7: A read of word 12 while idle with nothing pending returns the default vector and leaves the level idle.
- R8: A write to word 12 below idle restores the level saved at acknowledge, so nested levels unwind in reverse order. At idle the write has no effect. The written data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the strobe |
| src_pend | input | 32 | Raw pending sources, hardware or software |
| src_elig | input | 32 | Sources allowed onto the IRQ output |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen slots, thirty-two sources and 32-bit addresses. Those values reach the highest and lowest slot words, the word just outside each slot range, and a source bound to no slot, which falls through to level 16. Three slots bound to sources 7, 3 and 20 at slots 2, 5 and 9 nest three levels deep. The bench then unwinds them, with the pending pattern changed between pops so that `irq_out` reveals each restored level.

// File: rtl/vnp_pkg.sv
package vnp_pkg;
  // Control byte fields
  localparam int CTL_EN_BIT = 5;
  localparam int CTL_SRC_W  = 5;
  // Word addresses of the register groups
  localparam int WA_VECT     = 12;
  localparam int WA_DEFAULT  = 13;
  localparam int WA_SLOT_ADR = 64;
  localparam int WA_SLOT_CTL = 128;
endpackage

// File: rtl/vnp_slot_bank.sv
module vnp_slot_bank
  import vnp_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NSLOT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_adr,
  input  logic                          we_ctl,
  input  logic                          we_def,
  input  logic [IW-1:0]                 slot_idx,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 vaddr [NSLOT+1],
  output logic [7:0]                    ctl   [NSLOT],
  output logic [NSLOT+1:0][NSRC-1:0]    lvl_mask
);

  logic [NSLOT-1:0][NSRC-1:0] claim;

  // One-hot source claimed by an enabled slot, zero when disabled
  function automatic logic [NSRC-1:0] slot_claim(input logic [7:0] c);
    logic [NSRC-1:0] r;
    r = '0;
    if (c[CTL_EN_BIT]) r[c[CTL_SRC_W-1:0]] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= NSLOT; k++) vaddr[k] <= '0;
      for (int k = 0; k < NSLOT; k++)  ctl[k]   <= '0;
    end else begin
      if (we_adr) vaddr[slot_idx]  <= wdata;
      if (we_def) vaddr[NSLOT]     <= wdata;
      if (we_ctl) ctl[slot_idx]    <= wdata[7:0];
    end
  end

  // Cumulative masks: level L sees the claims of slots 0..L-1
  assign lvl_mask[0] = '0;
  for (genvar g = 0; g < NSLOT; g++) begin : g_chain
    assign claim[g]      = slot_claim(ctl[g]);
    assign lvl_mask[g+1] = lvl_mask[g] | claim[g];
  end
  assign lvl_mask[NSLOT+1] = '1;

endmodule

// File: rtl/vnp_level_stack.sv
module vnp_level_stack #(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  localparam int LW   = $clog2(NSLOT+2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ack_req,
  input  logic                       pop_req,
  input  logic [NSRC-1:0]            raw_pend,
  input  logic [NSLOT+1:0][NSRC-1:0] lvl_mask,
  output logic [LW-1:0]              cur_lvl,
  output logic [LW-1:0]              ack_lvl
);

  localparam logic [LW-1:0] IDLE = LW'(NSLOT+1);

  logic [LW-1:0] saved [NSLOT+1];
  logic          push_ev;
  logic          pop_ev;
  logic          nothing_pend;

  // First level above cur whose next-deeper mask meets the pending set
  function automatic logic [LW-1:0] pick_level(
      input logic [NSRC-1:0]            p,
      input logic [NSLOT+1:0][NSRC-1:0] m,
      input logic [LW-1:0]              cur);
    logic [LW-1:0] r;
    logic          hit;
    r   = cur;
    hit = 1'b0;
    for (int i = 0; i <= NSLOT; i++) begin
      if (!hit && (LW'(i) < cur) && ((p & m[i+1]) != '0)) begin
        r   = LW'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign ack_lvl      = pick_level(raw_pend, lvl_mask, cur_lvl);
  assign push_ev      = ack_req && (ack_lvl < cur_lvl);
  assign pop_ev       = pop_req && (cur_lvl != IDLE);
  assign nothing_pend = (raw_pend == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl <= IDLE;
      for (int k = 0; k <= NSLOT; k++) saved[k] <= IDLE;
    end else if (push_ev) begin
      saved[ack_lvl] <= cur_lvl;
      cur_lvl        <= ack_lvl;
    end else if (pop_ev) begin
      cur_lvl <= saved[cur_lvl];
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl <= IDLE); // R1
  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (cur_lvl < $past(cur_lvl))); // R5
  AST_EMPTY_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && nothing_pend) |=> $stable(cur_lvl)); // R7
  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (cur_lvl > $past(cur_lvl))); // R8
  AST_IDLE_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cur_lvl == IDLE) |=> (cur_lvl == IDLE)); // R8

endmodule

// File: rtl/vnp_irq_nest.sv
module vnp_irq_nest
  import vnp_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NSRC-1:0] src_pend,
  input  logic [NSRC-1:0] src_elig,
  output logic          irq_out
);

  localparam int IW = $clog2(NSLOT);
  localparam int LW = $clog2(NSLOT+2);
  localparam logic [LW-1:0] IDLE = LW'(NSLOT+1);

  logic                       rd_ev, wr_ev;
  logic                       hit_vect, hit_def, hit_sa, hit_sc;
  logic [IW-1:0]              idx;
  logic [DW-1:0]              vaddr [NSLOT+1];
  logic [7:0]                 ctl   [NSLOT];
  logic [NSLOT+1:0][NSRC-1:0] lvl_mask;
  logic [LW-1:0]              cur_lvl, ack_lvl;
  logic [DW-1:0]              rd_val;
  logic                       irq_next;

  assign rd_ev    = bus_sel && !bus_wr;
  assign wr_ev    = bus_sel &&  bus_wr;
  assign hit_vect = (bus_waddr == AW'(WA_VECT));
  assign hit_def  = (bus_waddr == AW'(WA_DEFAULT));
  assign hit_sa   = (bus_waddr >= AW'(WA_SLOT_ADR)) && (bus_waddr < AW'(WA_SLOT_ADR + NSLOT));
  assign hit_sc   = (bus_waddr >= AW'(WA_SLOT_CTL)) && (bus_waddr < AW'(WA_SLOT_CTL + NSLOT));
  assign idx      = hit_sa ? IW'(bus_waddr - AW'(WA_SLOT_ADR))
                           : IW'(bus_waddr - AW'(WA_SLOT_CTL));

  vnp_slot_bank #(.NSLOT(NSLOT), .NSRC(NSRC), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_adr   (wr_ev && hit_sa),
    .we_ctl   (wr_ev && hit_sc),
    .we_def   (wr_ev && hit_def),
    .slot_idx (idx),
    .wdata    (bus_wdata),
    .vaddr    (vaddr),
    .ctl      (ctl),
    .lvl_mask (lvl_mask)
  );

  vnp_level_stack #(.NSLOT(NSLOT), .NSRC(NSRC)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_req  (rd_ev && hit_vect),
    .pop_req  (wr_ev && hit_vect),
    .raw_pend (src_pend),
    .lvl_mask (lvl_mask),
    .cur_lvl  (cur_lvl),
    .ack_lvl  (ack_lvl)
  );

  always_comb begin
    rd_val = '0;
    if (hit_vect)     rd_val = (ack_lvl == IDLE) ? vaddr[NSLOT] : vaddr[ack_lvl];
    else if (hit_def) rd_val = vaddr[NSLOT];
    else if (hit_sa)  rd_val = vaddr[idx];
    else if (hit_sc)  rd_val = DW'(ctl[idx]);
  end

  assign irq_next = ((src_pend & src_elig & lvl_mask[cur_lvl]) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (rd_ev) bus_rdata <= rd_val;
      irq_out <= irq_next;
    end
  end

  AST_TOP_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == '0) |=> !irq_out); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !hit_vect && !hit_def && !hit_sa && !hit_sc) |=> (bus_rdata == '0)); // R2

endmodule

// File: tb/vnp_irq_nest_test.sv
`timescale 1ns/1ps
module vnp_irq_nest_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_pend = '0;
  logic [31:0] src_elig = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vnp_irq_nest uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pend(src_pend), .src_elig(src_elig), .irq_out(irq_out)
  );

  // {word address, write data, expected read-back}
  localparam int NTBL = 8;
  localparam logic [73:0] TBL [NTBL] = '{
    {10'd64,  32'h0000_1000, 32'h0000_1000},
    {10'd79,  32'h0000_2F00, 32'h0000_2F00},
    {10'd128, 32'h0000_01FF, 32'h0000_00FF},
    {10'd143, 32'h0000_0023, 32'h0000_0023},
    {10'd13,  32'hDEAD_0000, 32'hDEAD_0000},
    {10'd63,  32'h0000_0005, 32'h0000_0000},
    {10'd80,  32'h0000_0006, 32'h0000_0000},
    {10'd0,   32'h0000_0007, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_pend = '0; src_elig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1: reset state
    rd(10'd64, v);  check("R1 slot0 addr", v, 32'h0);
    rd(10'd79, v);  check("R1 slot15 addr", v, 32'h0);
    rd(10'd128, v); check("R1 slot0 ctl", v, 32'h0);
    rd(10'd13, v);  check("R1 default", v, 32'h0);
    check("R1 irq low", {31'b0, irq_out}, 32'h0);
    src_pend = 32'h8000_0000; src_elig = '1; step();
    check("R1 idle level admits any source", {31'b0, irq_out}, 32'h1);
    src_pend = '0; src_elig = '0; step();

    // R2: register map read-back table
    for (int i = 0; i < NTBL; i++) begin
      wr(TBL[i][73:64], TBL[i][63:32]);
      rd(TBL[i][73:64], v);
      check("R2 readback", v, TBL[i][31:0]);
    end

    do_reset();
    // Slots 2,5,9 -> sources 7,3,20 ; bit 5 enable
    wr(10'd66, 32'h0000_A020); wr(10'd130, 32'h27);
    wr(10'd69, 32'h0000_A050); wr(10'd133, 32'h23);
    wr(10'd73, 32'h0000_A090); wr(10'd137, 32'h34);
    wr(10'd13, 32'h0000_D0D0);

    // R7: empty acknowledge
    rd(10'd12, v); check("R7 empty read gives default", v, 32'h0000_D0D0);
    src_pend = 32'h1 << 20; step();
    check("R4 ineligible source masked", {31'b0, irq_out}, 32'h0);
    src_elig = '1; step();
    check("R7 level stayed idle", {31'b0, irq_out}, 32'h1);

    // R5: nest three deep
    rd(10'd12, v); check("R5 ack slot9", v, 32'h0000_A090);
    step(); check("R4 level9 masks src20", {31'b0, irq_out}, 32'h0);
    src_pend = src_pend | (32'h1 << 3); step();
    check("R4 src3 above level9", {31'b0, irq_out}, 32'h1);
    rd(10'd12, v); check("R5 ack slot5", v, 32'h0000_A050);
    step(); check("R4 level5 masks src3", {31'b0, irq_out}, 32'h0);
    src_pend = src_pend | (32'h1 << 7); step();
    check("R4 src7 above level5", {31'b0, irq_out}, 32'h1);
    rd(10'd12, v); check("R5 ack slot2", v, 32'h0000_A020);
    step(); check("R4 level2 masks all", {31'b0, irq_out}, 32'h0);
    rd(10'd12, v); check("R6 reread same level", v, 32'h0000_A020);
    step(); check("R6 level unchanged", {31'b0, irq_out}, 32'h0);

    // R8: unwind
    wr(10'd12, 32'hFFFF_FFFF); step();
    check("R8 pop to level5", {31'b0, irq_out}, 32'h1);
    src_pend = (32'h1 << 20) | (32'h1 << 3); step();
    check("R8 level5 confirmed", {31'b0, irq_out}, 32'h0);
    wr(10'd12, 32'h0); step();
    check("R8 pop to level9", {31'b0, irq_out}, 32'h1);
    src_pend = 32'h1 << 20; step();
    check("R8 level9 confirmed", {31'b0, irq_out}, 32'h0);
    wr(10'd12, 32'h0); step();
    check("R8 pop to idle", {31'b0, irq_out}, 32'h1);
    wr(10'd12, 32'h0); step();
    check("R8 idle pop no effect", {31'b0, irq_out}, 32'h1);
    rd(10'd12, v); check("R8 still idle before ack", v, 32'h0000_A090);
    wr(10'd12, 32'h0);

    // R5: unvectored source reaches default level
    src_pend = 32'h1 << 30; step();
    check("R4 unvectored at idle", {31'b0, irq_out}, 32'h1);
    rd(10'd12, v); check("R5 unvectored gives default", v, 32'h0000_D0D0);
    step(); check("R4 level16 masks unvectored", {31'b0, irq_out}, 32'h0);
    src_pend = src_pend | (32'h1 << 20); step();
    check("R4 claimed source above level16", {31'b0, irq_out}, 32'h1);
    wr(10'd12, 32'h0);

    // R3: disabling a slot makes its source unvectored
    src_pend = 32'h1 << 3;
    rd(10'd12, v); check("R3 enabled slot5", v, 32'h0000_A050);
    wr(10'd12, 32'h0);
    wr(10'd133, 32'h03);
    rd(10'd133, v); check("R3 ctl readback", v, 32'h03);
    rd(10'd12, v); check("R3 disabled slot falls to default", v, 32'h0000_D0D0);
    wr(10'd12, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule